// File: doc/BRIEF.md
# Translation Table Update Engine

This engine services maintenance commands against an IO page translation table. The table has `NUM_ENTRIES` 64-bit entries, and each entry maps one IO page of `2^PAGE_SHIFT` bytes. Every command names a table, an IO bus address, an argument, and a count. The argument is either an entry value or the address of a list in memory. Four commands are supported:

- store one entry;
- fetch one entry;
- replicate one value over a run of consecutive pages;
- load a run of consecutive pages from a list of big-endian 64-bit words held in memory.

Each command ends with a one-cycle `done` pulse and a status bit. Every entry that is actually written also produces an invalidation notice. The notice carries the page-aligned IO address, the page-aligned translated address, the in-page offset mask and the 2-bit permission.

The controller is a five-state machine:

- **IDLE** registers a command when `cmd_valid` is seen, then goes to **CHECK**.
- **CHECK** validates the table identifier, the count and the list alignment.
  - A failure, or any read command, goes to **DONE**.
  - A list command goes to **FETCH**.
  - A single store or a fill goes to **WRITE**.
- **FETCH** holds a memory request until the response arrives, then goes to **WRITE**.
- **WRITE** stores one entry and steps one page forward.
  - It goes to **DONE** on an out-of-range page or after the last entry.
  - Otherwise it goes back to **FETCH** for a list command, or stays in **WRITE** for a fill.
- **DONE** pulses `done` and returns to **IDLE**.

Top module: `xlat_table_engine`

## Requirements
- R1: After reset every entry reads as zero, `cmd_ready` is 1, and `done` and `mem_req` are 0.
- R2: A command whose `cmd_table[63:32]` is nonzero, or whose `cmd_table[31:0]` differs from `TABLE_ID`, ends with status 1. It writes nothing and emits no notice.
- R3: The IO address is first cleared in its low `PAGE_SHIFT` bits. The entry index is then (address − `BUS_OFFSET`) >> `PAGE_SHIFT`, computed unsigned and modulo 2^64. Any index ≥ `NUM_ENTRIES` gives status 1 for that entry.
- R4: Op 0 (single store) writes `cmd_arg` to the indexed entry and ignores `cmd_count`. It emits exactly one notice with:
  - `ntf_iova` = aligned address;
  - `ntf_xlat` = `cmd_arg` with its low `PAGE_SHIFT` bits cleared;
  - `ntf_mask` = 2^`PAGE_SHIFT`−1;
  - `ntf_perm` = `cmd_arg[1:0]`, where 0 means none, 1 read, 2 write and 3 both.
- R5: Op 1 (single fetch) drives the stored entry on `rd_data` with status 0. On any failure `rd_data` keeps its previous value.
- R6: Op 2 (fill) writes `cmd_arg` to `cmd_count` consecutive pages. A count of 0, or a count above `NUM_ENTRIES`, gives status 1 with no write.
- R7: Op 3 (list load) is rejected with status 1, and no memory request, in any of these cases:
  - the count is 0;
  - the count is above 512;
  - `cmd_arg[11:0]` is nonzero.

  Otherwise entry k is read from `cmd_arg + 8k`. Byte lane j of `mem_rsp_data` (`[8j+7:8j]`) holds the byte at address+j, and the byte at the lowest address is the most significant byte of the entry.
- R8: Multi-entry commands walk pages in ascending order and stop at the first out-of-range page with status 1. Earlier pages stay written, and no later page is fetched or written.
- R9: Status 0 means success and 1 means parameter error. `done` is a single-cycle pulse per accepted command and is never high together with a notice or a memory request.
- R10: `cmd_valid` is ignored while `cmd_ready` is 0, including during the `done` cycle.
- R11: A command is taken when `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` drops the next cycle. `mem_req` stays high, with a stable `mem_addr`, until a cycle in which `mem_rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_op | input | 2 | 0 store, 1 fetch, 2 fill, 3 list load |
| cmd_table | input | 64 | Table identifier |
| cmd_ioaddr | input | 64 | IO bus address |
| cmd_arg | input | 64 | Entry value or list address |
| cmd_count | input | 32 | Entry count for multi-entry ops |
| done | output | 1 | Completion pulse |
| status | output | 1 | 0 success, 1 parameter error |
| rd_data | output | 64 | Entry returned by a fetch |
| ntf_valid | output | 1 | Invalidation notice valid |
| ntf_iova | output | 64 | Page-aligned IO address |
| ntf_xlat | output | 64 | Page-aligned translated address |
| ntf_mask | output | 64 | In-page offset mask |
| ntf_perm | output | 2 | Permission of the written entry |
| mem_req | output | 1 | List word request |
| mem_addr | output | 64 | List word address |
| mem_rsp_valid | input | 1 | List word returned |
| mem_rsp_data | input | 64 | List word, byte j at address+j |

## Verification
Two events can meet in one cycle. The first is a new command on `cmd_valid`. The second is the engine's own busy work: an entry write during a fill walk, or the final `done` cycle.

The bench provokes this by starting a long fill and then holding `cmd_valid` high with a single store to a different page. The store stays asserted through the whole walk and through the `done` cycle, and is released only in the cycle where `done` is sampled. The bench then judges the outcome at the ports. It reads back the page the ignored store targeted and checks that the value matches the expected table. It also checks that the notice count matches the fill alone.

// File: rtl/xte_pkg.sv
package xte_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_WRITE,
        S_DONE
    } state_e;

    localparam logic ST_OK    = 1'b0;
    localparam logic ST_PARAM = 1'b1;

endpackage

// File: rtl/xte_index.sv
// Page index and bounds decode for one page-aligned IO address.
module xte_index #(
    parameter int                ADDR_W      = 64,
    parameter int                NUM_ENTRIES = 16,
    parameter int                PAGE_SHIFT  = 12,
    parameter logic [ADDR_W-1:0] BUS_OFFSET  = '0,
    parameter int                IDX_W       = 4
) (
    input  logic [ADDR_W-1:0] page_addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] page;

    assign rel      = page_addr - BUS_OFFSET;
    assign page     = rel >> PAGE_SHIFT;
    assign in_range = page < ADDR_W'(NUM_ENTRIES);
    assign idx      = page[IDX_W-1:0];
endmodule

// File: rtl/xte_store.sv
// Entry storage: one write port, one asynchronous read port, cleared on reset.
module xte_store #(
    parameter int DATA_W      = 64,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] ent [NUM_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent[i] <= '0;
            end
        end else if (wr_en) begin
            ent[wr_idx] <= wr_data;
        end
    end

    assign rd_data = ent[rd_idx];
endmodule

// File: rtl/xlat_table_engine.sv
module xlat_table_engine
    import xte_pkg::*;
#(
    parameter int                DATA_W           = 64,
    parameter int                CNT_W            = 32,
    parameter int                NUM_ENTRIES      = 16,
    parameter int                PAGE_SHIFT       = 12,
    parameter logic [DATA_W-1:0] BUS_OFFSET       = 64'h0000_0000_8000_0000,
    parameter logic [31:0]       TABLE_ID         = 32'h0000_1001,
    parameter int                LIST_MAX         = 512,
    parameter int                LIST_ALIGN_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_table,
    input  logic [DATA_W-1:0] cmd_ioaddr,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              done,
    output logic              status,
    output logic [DATA_W-1:0] rd_data,
    output logic              ntf_valid,
    output logic [DATA_W-1:0] ntf_iova,
    output logic [DATA_W-1:0] ntf_xlat,
    output logic [DATA_W-1:0] ntf_mask,
    output logic [1:0]        ntf_perm,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int                IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int                BYTES    = DATA_W / 8;
    localparam logic [DATA_W-1:0] PAGE_SZ  = DATA_W'(1) << PAGE_SHIFT;
    localparam logic [DATA_W-1:0] LOW_MASK = PAGE_SZ - DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP     = DATA_W'(BYTES);

    state_e            state_q, state_d;
    op_e               op_q;
    logic [DATA_W-1:0] tbl_q, addr_q, ptr_q, val_q, rd_q;
    logic [CNT_W-1:0]  left_q;
    logic              err_q;

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              wr_en;
    logic [DATA_W-1:0] ent_rd;
    logic [DATA_W-1:0] rsp_be;
    logic              id_ok, multi, args_bad, last;

    xte_index #(
        .ADDR_W     (DATA_W),
        .NUM_ENTRIES(NUM_ENTRIES),
        .PAGE_SHIFT (PAGE_SHIFT),
        .BUS_OFFSET (BUS_OFFSET),
        .IDX_W      (IDX_W)
    ) u_index (
        .page_addr(addr_q),
        .idx      (idx),
        .in_range (hit)
    );

    assign wr_en = (state_q == S_WRITE) && hit;

    xte_store #(
        .DATA_W     (DATA_W),
        .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (idx),
        .wr_data(val_q),
        .rd_idx (idx),
        .rd_data(ent_rd)
    );

    // Lowest-address byte (lane 0) becomes the most significant byte.
    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign rsp_be[8*b +: 8] = mem_rsp_data[DATA_W-8-8*b +: 8];
    end

    // Command validation terms
    always_comb begin
        id_ok    = (tbl_q[DATA_W-1:32] == '0) && (tbl_q[31:0] == TABLE_ID);
        multi    = (op_q == OP_FILL) || (op_q == OP_LIST);
        args_bad = 1'b0;
        if (multi && (left_q == '0)) begin
            args_bad = 1'b1;
        end
        if ((op_q == OP_FILL) && (left_q > CNT_W'(NUM_ENTRIES))) begin
            args_bad = 1'b1;
        end
        if ((op_q == OP_LIST) &&
            ((left_q > CNT_W'(LIST_MAX)) || (ptr_q[LIST_ALIGN_SHIFT-1:0] != '0))) begin
            args_bad = 1'b1;
        end
        last = (left_q == CNT_W'(1));
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_CHECK;
            S_CHECK: begin
                if (!id_ok || args_bad || (op_q == OP_GET)) state_d = S_DONE;
                else if (op_q == OP_LIST)                    state_d = S_FETCH;
                else                                         state_d = S_WRITE;
            end
            S_FETCH: if (mem_rsp_valid) state_d = S_WRITE;
            S_WRITE: begin
                if (!hit || last)          state_d = S_DONE;
                else if (op_q == OP_LIST)  state_d = S_FETCH;
                else                       state_d = S_WRITE;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_PUT;
            tbl_q  <= '0;
            addr_q <= '0;
            ptr_q  <= '0;
            val_q  <= '0;
            rd_q   <= '0;
            left_q <= '0;
            err_q  <= ST_OK;
        end else begin
            case (state_q)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= op_e'(cmd_op);
                    tbl_q  <= cmd_table;
                    addr_q <= cmd_ioaddr & ~LOW_MASK;
                    ptr_q  <= cmd_arg;
                    val_q  <= cmd_arg;
                    left_q <= cmd_op[1] ? cmd_count : CNT_W'(1);
                    err_q  <= ST_OK;
                end
                S_CHECK: begin
                    if (!id_ok || args_bad) begin
                        err_q <= ST_PARAM;
                    end else if (op_q == OP_GET) begin
                        if (hit) rd_q  <= ent_rd;
                        else     err_q <= ST_PARAM;
                    end
                end
                S_FETCH: if (mem_rsp_valid) begin
                    val_q <= rsp_be;
                    ptr_q <= ptr_q + STEP;
                end
                S_WRITE: begin
                    if (!hit) begin
                        err_q <= ST_PARAM;
                    end else begin
                        addr_q <= addr_q + PAGE_SZ;
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        done      = (state_q == S_DONE);
        status    = err_q;
        rd_data   = rd_q;
        mem_req   = (state_q == S_FETCH);
        mem_addr  = ptr_q;
        ntf_valid = wr_en;
        ntf_iova  = addr_q;
        ntf_xlat  = val_q & ~LOW_MASK;
        ntf_mask  = LOW_MASK;
        ntf_perm  = val_q[1:0];
    end
endmodule

// File: rtl/xlat_table_engine_chk.sv
module xlat_table_engine_chk #(
    parameter int DATA_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done,
    input logic              ntf_valid,
    input logic [DATA_W-1:0] ntf_iova,
    input logic [DATA_W-1:0] ntf_xlat,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_rsp_valid
);
    localparam logic [DATA_W-1:0] LOW = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ntf_valid && !mem_req));

    // R10
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R7
    idle_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req);

    // R4
    ntf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (((ntf_iova | ntf_xlat) & LOW) == '0));
endmodule

bind xlat_table_engine xlat_table_engine_chk #(
    .DATA_W    (DATA_W),
    .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .done         (done),
    .ntf_valid    (ntf_valid),
    .ntf_iova     (ntf_iova),
    .ntf_xlat     (ntf_xlat),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/xlat_table_engine_tb.sv
`timescale 1ns/1ps
module xlat_table_engine_tb;
    localparam logic [63:0] OFF = 64'h0000_0000_8000_0000;
    localparam logic [63:0] TID = 64'h0000_0000_0000_1001;
    localparam logic [63:0] PG  = 64'h1000;
    localparam logic [63:0] LOW = 64'hFFF;
    localparam int          NE  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_table = '0, cmd_ioaddr = '0, cmd_arg = '0;
    logic [31:0] cmd_count = '0;
    logic        done, status;
    logic [63:0] rd_data;
    logic        ntf_valid;
    logic [63:0] ntf_iova, ntf_xlat, ntf_mask;
    logic [1:0]  ntf_perm;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    xlat_table_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_table(cmd_table), .cmd_ioaddr(cmd_ioaddr),
        .cmd_arg(cmd_arg), .cmd_count(cmd_count), .done(done), .status(status),
        .rd_data(rd_data), .ntf_valid(ntf_valid), .ntf_iova(ntf_iova),
        .ntf_xlat(ntf_xlat), .ntf_mask(ntf_mask), .ntf_perm(ntf_perm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [63:0] shadow [NE];
    logic [63:0] exp_rd;
    logic        exp_st;
    int          exp_n, exp_f, got_n, fetch_n;
    logic [63:0] e_iova [32], e_xlat [32], g_iova [32], g_xlat [32], g_mask [32];
    logic [1:0]  e_perm [32], g_perm [32];

    function automatic logic [63:0] list_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hC0DE_0000, a[27:0], 2'b00, a[4:3]};
    endfunction

    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[8*j +: 8] = v[63-8*j -: 8];
        return r;
    endfunction

    // Memory: one-cycle-late response, data depends on the address only
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req && !mem_rsp_valid;
        mem_rsp_data  <= to_lanes(list_word(mem_addr));
        if (mem_req && !mem_rsp_valid) fetch_n++;
    end

    always @(negedge clk) begin
        if (ntf_valid) begin
            if (got_n < 32) begin
                g_iova[got_n] = ntf_iova; g_xlat[got_n] = ntf_xlat;
                g_mask[got_n] = ntf_mask; g_perm[got_n] = ntf_perm;
            end
            got_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference behaviour derived from the requirements
    task automatic model(input logic [1:0] op, input logic [63:0] id, addr, arg,
                         input logic [31:0] cnt);
        logic [63:0] a, pa, v, pg;
        int n;
        exp_n = 0; exp_f = 0; exp_st = 1'b0; n = 0;
        a = addr & ~LOW;
        if (id[63:32] != 0 || id[31:0] != TID[31:0]) exp_st = 1'b1;
        else begin
            case (op)
                2'd0: n = 1;
                2'd1: begin
                    pg = (a - OFF) >> 12;
                    if (pg < NE) exp_rd = shadow[pg[3:0]];
                    else exp_st = 1'b1;
                end
                2'd2: if (cnt == 0 || cnt > NE) exp_st = 1'b1; else n = int'(cnt);
                default: if (cnt == 0 || cnt > 512 || arg[11:0] != 0) exp_st = 1'b1;
                         else n = int'(cnt);
            endcase
        end
        for (int k = 0; k < n; k++) begin
            if (op == 2'd3) begin v = list_word(arg + 64'(8*k)); exp_f++; end
            else v = arg;
            pa = a + PG * 64'(k);
            pg = (pa - OFF) >> 12;
            if (pg >= NE) begin exp_st = 1'b1; break; end
            shadow[pg[3:0]] = v;
            e_iova[exp_n] = pa; e_xlat[exp_n] = v & ~LOW; e_perm[exp_n] = v[1:0];
            exp_n++;
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] id, addr, arg,
                       input logic [31:0] cnt, input bit hold_busy, input string req);
        int w;
        model(op, id, addr, arg, cnt);
        got_n = 0; fetch_n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_table = id; cmd_ioaddr = addr;
        cmd_arg = arg; cmd_count = cnt;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R11", "ready after accept", 64'(cmd_ready), 64'd0);
        if (hold_busy) begin   // R10: competing store offered through the walk
            cmd_op = 2'd0; cmd_table = TID; cmd_ioaddr = OFF + 9 * PG;
            cmd_arg = 64'hDEAD_BEEF_0000_0003; cmd_count = 1;
        end else cmd_valid = 1'b0;
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        if (w >= 5000) chk(1'b0, req, "command timeout", 64'(w), 64'd0);
        cmd_valid = 1'b0;
        chk(status == exp_st, req, "status", 64'(status), 64'(exp_st));
        chk(got_n == exp_n, req, "notice count", 64'(got_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk(g_iova[k] == e_iova[k], "R4", "notice iova", g_iova[k], e_iova[k]);
            chk(g_xlat[k] == e_xlat[k], "R4", "notice xlat", g_xlat[k], e_xlat[k]);
            chk({g_mask[k], g_perm[k]} == {LOW, e_perm[k]}, "R4", "notice mask/perm",
                64'({g_mask[k][11:0], g_perm[k]}), 64'({LOW[11:0], e_perm[k]}));
        end
        chk(fetch_n == exp_f, "R7", "fetch count", 64'(fetch_n), 64'(exp_f));
        chk(rd_data == exp_rd, "R5", "rd_data", rd_data, exp_rd);
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R9", "single done pulse",
            64'({done, cmd_ready}), 64'b01);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < NE; i++) run(2'd1, TID, OFF + PG * 64'(i), 0, 0, 0, req);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) shadow[i] = '0;
        exp_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !done && !mem_req, "R1", "reset outputs",
            64'({cmd_ready, done, mem_req}), 64'b100);
        sweep("R1");
        // R4: single stores with unaligned addresses and every permission
        for (int i = 0; i < NE; i++)
            run(2'd0, TID, OFF + PG * 64'(i) + 64'h123,
                {32'hABC0_0000 | 32'(i), 20'(i * 32'h1111), 12'h5A0 | 12'(i % 4)},
                32'd77, 0, "R4");
        // R2: identifier checks
        run(2'd0, TID | 64'h1_0000_0000, OFF, 64'h1234_5003, 1, 0, "R2");
        run(2'd0, TID ^ 64'h1, OFF + PG, 64'h1234_5003, 1, 0, "R2");
        run(2'd1, TID | 64'h8000_0000_0000_0000, OFF, 0, 0, 0, "R2");
        // R3: range edges
        run(2'd0, TID, OFF + PG * NE, 64'h7777_7001, 1, 0, "R3");
        run(2'd0, TID, OFF - PG, 64'h7777_7001, 1, 0, "R3");
        run(2'd0, TID, OFF + PG * (NE - 1) + LOW, 64'h6666_6002, 1, 0, "R3");
        run(2'd1, TID, OFF - 64'd1, 0, 0, 0, "R5");
        run(2'd1, TID, OFF + PG * 64'd3, 0, 0, 0, "R5");
        run(2'd1, TID, OFF + PG * 64'd40, 0, 0, 0, "R5");
        // R6: fill
        run(2'd2, TID, OFF + PG * 3, 64'h1111_2222_3333_4001, 4, 0, "R6");
        run(2'd2, TID, OFF, 64'h5555_0002, 0, 0, "R6");
        run(2'd2, TID, OFF, 64'h5555_0002, NE + 1, 0, "R6");
        run(2'd2, TID, OFF, 64'h9999_8003, NE, 0, "R6");
        run(2'd2, TID, OFF + PG * 14, 64'hAAAA_B001, 5, 0, "R8");
        sweep("R6");
        // R7: list load
        run(2'd3, TID, OFF + PG * 2, 64'h0001_0000, 3, 0, "R7");
        run(2'd3, TID, OFF, 64'h0001_0008, 2, 0, "R7");
        run(2'd3, TID, OFF, 64'h0002_0000, 513, 0, "R7");
        run(2'd3, TID, OFF, 64'h0002_0000, 0, 0, "R7");
        run(2'd3, TID, OFF + PG * 10, 64'h0003_0000, 512, 0, "R8");
        run(2'd3, TID, OFF, 64'h0004_0000, NE, 0, "R7");
        sweep("R7");
        // R10: competing command held while busy
        run(2'd2, TID, OFF, 64'h4242_0001, 8, 1, "R10");
        run(2'd1, TID, OFF + PG * 9, 0, 0, 0, "R10");
        sweep("R5");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule